// File: doc/BRIEF.md
# Skewed Multi-Bank Search Window Memory

This block holds a window of reference pixels for a motion search engine. It spreads the window over a set of single-port banks, each one pixel wide. Pixel column c of row r goes to bank (c + r) mod LANES, at word r * (WIN_W / LANES) + floor(c / LANES). Because of this diagonal skew, any LANES horizontally adjacent pixels and any LANES vertically adjacent pixels fall in LANES different banks. Either kind of run can therefore be fetched in a single access. That lets a search pattern step one pixel in any of the four directions without stalling.

The window is loaded one aligned row segment of LANES pixels per cycle. A read names a start coordinate and an orientation, either a run along a row or a run down a column. One cycle later the block returns the pixels in logical order: lane k holds the k-th pixel of the run. An address generator forms a separate word address for each bank, and a barrel rotator undoes the skew on the way out. A mode input turns the skew off, so the plain interleaved layout can be compared. In that mode only row runs can be served.

Top module: `skew_window_mem`

## Requirements
- R1: After reset, and before any read request, `rd_valid` and `rd_reject` are both 0.
- R2: With `wr_en`=1, lane k of `wr_data` (bits [8k+7:8k]) is stored as the pixel at row `wr_row`, column 16*`wr_seg`+k. A later read returns that pixel.
- R3: With `skew_en`=1, a row request (`rd_vert`=0) at (r, c) with c <= WIN_W-16 gives `rd_valid`=1 in the next cycle. In that cycle, lane k of `rd_data` holds pixel (r, c+k), for any c, aligned or not.
- R4: With `skew_en`=1, a column request (`rd_vert`=1) at (r, c) with r <= WIN_H-16 gives `rd_valid`=1 in the next cycle. In that cycle, lane k of `rd_data` holds pixel (r+k, c).
- R5: With `skew_en`=0, for a window loaded in that mode, row requests return the same data, with the same timing, as in R3.
- R6: With `skew_en`=0, a column request is not served. In the next cycle `rd_reject`=1 and `rd_valid`=0.
- R7: When `wr_en` and `rd_en` are both 1 in the same cycle, the write wins. It is stored, the read is rejected (`rd_reject`=1, `rd_valid`=0 in the next cycle), and a later read returns the written data.
- R8: A row request with c > WIN_W-16, or a column request with r > WIN_H-16, is rejected in the next cycle. Nothing is read.
- R9: `rd_data` changes only in the cycle after an accepted read. It holds its value across idle cycles, writes and rejected requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| skew_en | input | 1 | 1 = diagonal skew layout, 0 = plain interleave |
| wr_en | input | 1 | Store one row segment this cycle |
| wr_row | input | $clog2(WIN_H) | Row of the segment being written |
| wr_seg | input | $clog2(WIN_W/LANES) | Aligned segment index within the row |
| wr_data | input | LANES*PIX_W | Segment pixels, lane k = column 16*seg+k |
| rd_en | input | 1 | Read request this cycle |
| rd_row | input | $clog2(WIN_H) | Start row of the run |
| rd_col | input | $clog2(WIN_W) | Start column of the run |
| rd_vert | input | 1 | 0 = run along a row, 1 = run down a column |
| rd_valid | output | 1 | `rd_data` carries the result of last cycle's request |
| rd_reject | output | 1 | Last cycle's request was not served |
| rd_data | output | LANES*PIX_W | Run pixels in logical order, lane k at bits [8k+7:8k] |

## Verification
The assertions check the request handshake on every cycle. They cover the outcome of a request colliding with a write, of a column request in plain mode and of an out-of-range start, the acceptance of in-range row requests, and that the output holds while no request is made. Whether the returned pixels are the right ones, in the right lanes, for unaligned row starts and for column runs that cross every bank, can only be shown by the bench's scenarios. The same applies to write data winning a collision, and to the plain layout agreeing with the skewed one on row runs.

// File: rtl/swm_pkg.sv
package swm_pkg;
  typedef enum logic {
    ORIENT_ROW = 1'b0,
    ORIENT_COL = 1'b1
  } orient_e;
endpackage

// File: rtl/swm_bank.sv
module swm_bank #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [PIX_W-1:0] wdata,
  output logic [PIX_W-1:0] rdata
);
  logic [PIX_W-1:0] mem [DEPTH];

  // single port: a write takes the port, a read only when no write
  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end else if (re) begin
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/swm_addr_gen.sv
module swm_addr_gen #(
  parameter int LANES = 16,
  parameter int WIN_W = 64,
  parameter int WIN_H = 32,
  localparam int LW = $clog2(LANES),
  localparam int CW = $clog2(WIN_W),
  localparam int RW = $clog2(WIN_H),
  localparam int SW = $clog2(WIN_W / LANES),
  localparam int AW = RW + SW
) (
  input  logic                      skew_en,
  input  logic [RW-1:0]             wr_row,
  input  logic [SW-1:0]             wr_seg,
  input  logic [RW-1:0]             rd_row,
  input  logic [CW-1:0]             rd_col,
  input  swm_pkg::orient_e          rd_orient,
  output logic [AW-1:0]             wr_addr,
  output logic [LW-1:0]             wr_shift,
  output logic [LW-1:0]             rd_rot,
  output logic [LANES-1:0][AW-1:0]  bank_rd_addr
);
  always_comb begin
    wr_addr  = {wr_row, wr_seg};
    wr_shift = skew_en ? LW'(wr_row) : '0;
    rd_rot   = skew_en ? LW'(rd_row) + LW'(rd_col) : LW'(rd_col);
  end

  for (genvar b = 0; b < LANES; b++) begin : g_bank_addr
    logic [LW-1:0] lane;
    logic [CW-1:0] col_k;
    logic [RW-1:0] row_k;
    always_comb begin
      lane  = LW'(b) - rd_rot;
      col_k = rd_col + CW'(lane);
      row_k = rd_row + RW'(lane);
      if (rd_orient == swm_pkg::ORIENT_COL) begin
        bank_rd_addr[b] = {row_k, rd_col[CW-1:LW]};
      end else begin
        bank_rd_addr[b] = {rd_row, col_k[CW-1:LW]};
      end
    end
  end
endmodule

// File: rtl/swm_rotator.sv
module swm_rotator #(
  parameter int LANES = 16,
  parameter int PIX_W = 8,
  localparam int LW = $clog2(LANES)
) (
  input  logic [LANES*PIX_W-1:0] din,
  input  logic [LW-1:0]          rot,
  output logic [LANES*PIX_W-1:0] dout
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LW-1:0] src;
    always_comb begin
      src = LW'(k) + rot;
      dout[k*PIX_W +: PIX_W] = din[src*PIX_W +: PIX_W];
    end
  end
endmodule

// File: rtl/skew_window_mem.sv
module skew_window_mem #(
  parameter int PIX_W = 8,
  parameter int LANES = 16,
  parameter int WIN_W = 64,
  parameter int WIN_H = 32,
  localparam int LW = $clog2(LANES),
  localparam int CW = $clog2(WIN_W),
  localparam int RW = $clog2(WIN_H),
  localparam int SW = $clog2(WIN_W / LANES),
  localparam int AW = RW + SW,
  localparam int DEPTH = WIN_H * (WIN_W / LANES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   skew_en,
  input  logic                   wr_en,
  input  logic [RW-1:0]          wr_row,
  input  logic [SW-1:0]          wr_seg,
  input  logic [LANES*PIX_W-1:0] wr_data,
  input  logic                   rd_en,
  input  logic [RW-1:0]          rd_row,
  input  logic [CW-1:0]          rd_col,
  input  logic                   rd_vert,
  output logic                   rd_valid,
  output logic                   rd_reject,
  output logic [LANES*PIX_W-1:0] rd_data
);
  import swm_pkg::*;

  orient_e                   orient;
  logic [AW-1:0]             wr_addr;
  logic [LW-1:0]             wr_shift;
  logic [LW-1:0]             rd_rot;
  logic [LANES-1:0][AW-1:0]  bank_rd_addr;
  logic [LANES*PIX_W-1:0]    bank_q;
  logic                      row_ok, col_ok, in_range, accept;
  logic                      valid_q, valid_d, reject_q, reject_d;
  logic [LW-1:0]             rot_q, rot_d;

  assign orient = rd_vert ? ORIENT_COL : ORIENT_ROW;

  swm_addr_gen #(.LANES(LANES), .WIN_W(WIN_W), .WIN_H(WIN_H)) addr_i (
    .skew_en      (skew_en),
    .wr_row       (wr_row),
    .wr_seg       (wr_seg),
    .rd_row       (rd_row),
    .rd_col       (rd_col),
    .rd_orient    (orient),
    .wr_addr      (wr_addr),
    .wr_shift     (wr_shift),
    .rd_rot       (rd_rot),
    .bank_rd_addr (bank_rd_addr)
  );

  // request qualification
  always_comb begin
    row_ok   = ({1'b0, rd_col} <= (CW+1)'(WIN_W - LANES));
    col_ok   = ({1'b0, rd_row} <= (RW+1)'(WIN_H - LANES));
    in_range = (orient == ORIENT_COL) ? col_ok : row_ok;
    accept   = rd_en && !wr_en && in_range && (skew_en || orient == ORIENT_ROW);
    valid_d  = accept;
    reject_d = rd_en && !accept;
    rot_d    = accept ? rd_rot : rot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      reject_q <= 1'b0;
      rot_q    <= '0;
    end else begin
      valid_q  <= valid_d;
      reject_q <= reject_d;
      rot_q    <= rot_d;
    end
  end

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [LW-1:0]    src_lane;
    logic [PIX_W-1:0] wdata;
    logic [AW-1:0]    addr;
    always_comb begin
      src_lane = LW'(b) - wr_shift;
      wdata    = wr_data[src_lane*PIX_W +: PIX_W];
      addr     = wr_en ? wr_addr : bank_rd_addr[b];
    end
    swm_bank #(.PIX_W(PIX_W), .DEPTH(DEPTH)) bank_i (
      .clk   (clk),
      .we    (wr_en),
      .re    (accept),
      .addr  (addr),
      .wdata (wdata),
      .rdata (bank_q[b*PIX_W +: PIX_W])
    );
  end

  swm_rotator #(.LANES(LANES), .PIX_W(PIX_W)) rot_i (
    .din  (bank_q),
    .rot  (rot_q),
    .dout (rd_data)
  );

  assign rd_valid  = valid_q;
  assign rd_reject = reject_q;

  // R7: collision with a write loses the read
  p_collision_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |=> (rd_reject && !rd_valid));

  // R6: plain layout cannot serve a column run
  p_plain_col_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !skew_en && rd_vert) |=> (rd_reject && !rd_valid));

  // R8: row run past the right edge is rejected
  p_row_range_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_vert && (int'(rd_col) > WIN_W - LANES)) |=> rd_reject);

  // R3: an in-range row request with no write is served next cycle
  p_row_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !rd_vert && (int'(rd_col) <= WIN_W - LANES)) |=> (rd_valid && !rd_reject));

  // R9: without a request the output holds
  p_hold_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R1: no response without a request one cycle before
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && !rd_reject));
endmodule

// File: tb/skew_window_mem_tb_top.sv
module skew_window_mem_tb_top;
  localparam int PW = 8;
  localparam int L  = 16;
  localparam int W  = 64;
  localparam int H  = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           skew_en, wr_en, rd_en, rd_vert;
  logic [4:0]     wr_row, rd_row;
  logic [1:0]     wr_seg;
  logic [5:0]     rd_col;
  logic [L*PW-1:0] wr_data, rd_data;
  logic           rd_valid, rd_reject;

  logic [PW-1:0]  ref_px [H][W];
  int             n_tests = 0;
  int             n_fail  = 0;

  always #5 clk = ~clk;

  skew_window_mem #(.PIX_W(PW), .LANES(L), .WIN_W(W), .WIN_H(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .skew_en(skew_en), .wr_en(wr_en),
    .wr_row(wr_row), .wr_seg(wr_seg), .wr_data(wr_data), .rd_en(rd_en),
    .rd_row(rd_row), .rd_col(rd_col), .rd_vert(rd_vert),
    .rd_valid(rd_valid), .rd_reject(rd_reject), .rd_data(rd_data)
  );

  function automatic logic [PW-1:0] pix(int seed, int r, int c);
    return PW'(r * 37 + c * 11 + seed * 53 + r * c);
  endfunction

  task automatic check(bit ok, string req, logic [L*PW-1:0] act, logic [L*PW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_seg(int r, int s, int seed);
    @(negedge clk);
    wr_en  = 1'b1;
    wr_row = 5'(r);
    wr_seg = 2'(s);
    for (int k = 0; k < L; k++) begin
      wr_data[k*PW +: PW] = pix(seed, r, s * L + k);
      ref_px[r][s * L + k] = pix(seed, r, s * L + k);
    end
  endtask

  task automatic load_all(int seed);
    for (int r = 0; r < H; r++)
      for (int s = 0; s < W / L; s++)
        write_seg(r, s, seed);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [L*PW-1:0] expect_run(int r, int c, bit vert);
    logic [L*PW-1:0] e;
    for (int k = 0; k < L; k++)
      e[k*PW +: PW] = vert ? ref_px[r + k][c] : ref_px[r][c + k];
    return e;
  endfunction

  task automatic issue_read(int r, int c, bit vert);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_row  = 5'(r);
    rd_col  = 6'(c);
    rd_vert = vert;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_read(string req, int r, int c, bit vert);
    logic [L*PW-1:0] e;
    e = expect_run(r, c, vert);
    issue_read(r, c, vert);
    check(rd_valid && !rd_reject && rd_data == e, req, rd_data, e);
  endtask

  task automatic check_reject(string req, int r, int c, bit vert);
    issue_read(r, c, vert);
    check(rd_reject && !rd_valid, req, {rd_valid, rd_reject}, 2'b01);
  endtask

  task automatic t_reset;
    check(!rd_valid && !rd_reject, "R1 reset outputs", {rd_valid, rd_reject}, '0);
  endtask

  task automatic t_row_reads;
    check_read("R2 R3 row aligned (0,0)", 0, 0, 1'b0);
    check_read("R3 row unaligned (9,5)", 9, 5, 1'b0);
    check_read("R3 row last start (31,48)", 31, 48, 1'b0);
    check_read("R3 row crossing segment (20,27)", 20, 27, 1'b0);
  endtask

  task automatic t_col_reads;
    check_read("R4 column (0,0)", 0, 0, 1'b1);
    check_read("R4 column last start (16,63)", 16, 63, 1'b1);
    check_read("R4 column (7,20)", 7, 20, 1'b1);
  endtask

  task automatic t_hold;
    logic [L*PW-1:0] held;
    check_read("R9 setup row (2,4)", 2, 4, 1'b0);
    held = rd_data;
    write_seg(2, 0, 9);
    @(negedge clk);
    wr_en = 1'b0;
    check(rd_data == held && !rd_valid, "R9 hold across write", rd_data, held);
    check_reject("R9 setup reject", 0, 60, 1'b0);
    check(rd_data == held, "R9 hold across reject", rd_data, held);
    check_read("R2 rewritten segment (2,0)", 2, 0, 1'b0);
  endtask

  task automatic t_collision;
    @(negedge clk);
    wr_en  = 1'b1;
    wr_row = 5'd5;
    wr_seg = 2'd1;
    for (int k = 0; k < L; k++) begin
      wr_data[k*PW +: PW] = pix(21, 5, L + k);
      ref_px[5][L + k] = pix(21, 5, L + k);
    end
    rd_en   = 1'b1;
    rd_row  = 5'd5;
    rd_col  = 6'd16;
    rd_vert = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    check(rd_reject && !rd_valid, "R7 collision rejects read", {rd_valid, rd_reject}, 2'b01);
    check_read("R7 write won collision", 5, 16, 1'b0);
  endtask

  task automatic t_range;
    check_reject("R8 row start past edge", 3, 49, 1'b0);
    check_reject("R8 column start past edge", 17, 2, 1'b1);
  endtask

  task automatic t_plain;
    skew_en = 1'b0;
    load_all(3);
    check_read("R5 plain row (0,0)", 0, 0, 1'b0);
    check_read("R5 plain row unaligned (13,37)", 13, 37, 1'b0);
    check_reject("R6 plain column rejected", 0, 8, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1'b1, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    skew_en = 1'b1;
    wr_en = 1'b0;
    rd_en = 1'b0;
    rd_vert = 1'b0;
    wr_row = '0;
    wr_seg = '0;
    wr_data = '0;
    rd_row = '0;
    rd_col = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    load_all(1);
    t_row_reads();
    t_col_reads();
    t_hold();
    t_collision();
    t_range();
    t_plain();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule